// File: doc/BRIEF.md
# Deserializer Word Boundary Realigner

This block sits behind a 1:10 deserializer whose forwarded clock runs at half the bit rate and therefore marks no word boundary. It keeps the current and the previous parallel word in a 20-bit window and selects ten consecutive bits from it at a 4-bit bit offset. Each slip moves the selection one bit later in the serial stream.

A control state machine starts a search when the enable input goes high. It compares the selected word with a programmable pattern. On a mismatch it issues a slip, then lets the shifted data settle before it compares again. After two matching words in a row it raises the aligned flag and stops slipping. If ten slips in a row find no match, the boundary is back where it started. A wrap error flag is then raised and the search goes on.

Top module: `word_realigner`

## Requirements
- R1: Bit 0 of every word is the earliest bit in the serial stream. `word_out` bit j is bit (offset + j) of the window {current word, previous word}, with the previous word in window bits 0..9. It is registered one clock after the current word is captured. With a stream made of one repeated word `raw`, a locked output equals `pattern` once `raw[(i+offset) mod 10] = pattern[i]` for all i.
- R2: Each slip advances the offset by exactly one, wrapping from 9 to 0. The offset is 0 after reset and is not reset by a new enable. A search that starts at offset a and locks at offset b issues (b - a) mod 10 slips.
- R3: `slip` is high for one clock per boundary shift. Any two slips are separated by at least 3 clocks with `slip` low, during which no comparison is made.
- R4: A search starts only on a low-to-high transition of `align_en`. While `align_en` is low, no slip is issued.
- R5: `aligned` rises only after two consecutive compared words equal `pattern`. Once it is set, no slip is issued, whatever the incoming data.
- R6: `wrap_err` rises together with the 10th slip of a search that has found no match. It stays set and the search continues, so the block can still lock afterwards.
- R7: A new rising edge of `align_en` clears `aligned` and `wrap_err` on the next clock. Both keep their values while `align_en` is low.
- R8: After reset `word_out`, `slip`, `aligned` and `wrap_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| raw_word | input | 10 | Parallel word from the deserializer, bit 0 earliest |
| pattern | input | 10 | Alignment pattern searched for |
| align_en | input | 1 | Rising edge starts a search; low stops it |
| word_out | output | 10 | Word at the current boundary offset |
| slip | output | 1 | One-clock pulse for each boundary shift |
| aligned | output | 1 | Two consecutive matches seen |
| wrap_err | output | 1 | Ten slips without a match |

## Verification
The bench sets the stream phase to every kind of distance from the current offset: zero, one, several, and a distance that needs a wrap through offset 9. A slip counter that did not wrap, or an offset that reset on enable, would produce the wrong slip count. A stream with no match checks that the error appears on the tenth slip and not the ninth, and that the search keeps going afterwards. A design that stopped searching or cleared the error itself would fail there. Further tests change the data after lock and hold the enable low with unmatched data. A block that kept slipping in either case would be caught. A final re-enable checks that the flags are cleared.

// File: rtl/realign_pkg.sv
package realign_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_CMP,
        ST_LOCK
    } rl_state_e;

endpackage

// File: rtl/rl_window.sv
module rl_window #(
    parameter int W     = 10,
    parameter int OFF_W = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     raw_word,
    input  logic [OFF_W-1:0] offset,
    output logic [W-1:0]     word
);

    localparam int WIN = 2 * W;

    typedef struct packed {
        logic [W-1:0] cur;
        logic [W-1:0] prev;
        logic [W-1:0] word;
    } win_regs_t;

    win_regs_t        q, d;
    logic [WIN-1:0]   window;
    logic [W-1:0]     picked;

    assign window = {q.cur, q.prev};

    // one multiplexer per output bit
    for (genvar j = 0; j < W; j++) begin : g_pick
        always_comb begin
            picked[j] = 1'b0;
            for (int k = 0; k < W; k++) begin
                if (offset == OFF_W'(k)) picked[j] = window[k + j];
            end
        end
    end

    always_comb begin
        d      = q;
        d.prev = q.cur;
        d.cur  = raw_word;
        d.word = picked;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign word = q.word;

endmodule

// File: rtl/rl_ctrl.sv
module rl_ctrl
    import realign_pkg::*;
#(
    parameter int W         = 10,
    parameter int SETTLE    = 3,
    parameter int LOCK_HITS = 2,
    parameter int OFF_W     = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     word,
    input  logic [W-1:0]     pattern,
    input  logic             align_en,
    output logic [OFF_W-1:0] offset,
    output logic             slip,
    output logic             aligned,
    output logic             wrap_err
);

    localparam int CNT_W  = $clog2(SETTLE + 1);
    localparam int HIT_W  = $clog2(LOCK_HITS + 1);
    localparam int SLIP_W = $clog2(W + 1);

    typedef struct packed {
        rl_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [HIT_W-1:0]  hits;
        logic [SLIP_W-1:0] slips;
        logic [OFF_W-1:0]  off;
        logic              slip;
        logic              aligned;
        logic              err;
        logic              en_q;
    } ctrl_regs_t;

    ctrl_regs_t q, d;
    logic       match;

    assign match = (word == pattern);

    always_comb begin
        d      = q;
        d.slip = 1'b0;
        d.en_q = align_en;
        if (!align_en) begin
            d.st = ST_IDLE;
        end else begin
            case (q.st)
                ST_IDLE: begin
                    if (!q.en_q) begin
                        d.st      = ST_SETTLE;
                        d.cnt     = CNT_W'(SETTLE - 1);
                        d.hits    = '0;
                        d.slips   = '0;
                        d.aligned = 1'b0;
                        d.err     = 1'b0;
                    end
                end
                ST_SETTLE: begin
                    if (q.cnt == '0) d.st  = ST_CMP;
                    else             d.cnt = q.cnt - 1'b1;
                end
                ST_CMP: begin
                    if (match) begin
                        if (q.hits == HIT_W'(LOCK_HITS - 1)) begin
                            d.st      = ST_LOCK;
                            d.aligned = 1'b1;
                        end else begin
                            d.hits = q.hits + 1'b1;
                        end
                    end else begin
                        d.hits = '0;
                        d.slip = 1'b1;
                        d.off  = (q.off == OFF_W'(W - 1)) ? '0 : q.off + 1'b1;
                        if (q.slips == SLIP_W'(W - 1)) begin
                            d.err   = 1'b1;
                            d.slips = '0;
                        end else begin
                            d.slips = q.slips + 1'b1;
                        end
                        d.st  = ST_SETTLE;
                        d.cnt = CNT_W'(SETTLE - 1);
                    end
                end
                ST_LOCK: d.st = ST_LOCK;
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign offset   = q.off;
    assign slip     = q.slip;
    assign aligned  = q.aligned;
    assign wrap_err = q.err;

endmodule

// File: rtl/word_realigner.sv
module word_realigner #(
    parameter int W         = 10,
    parameter int SETTLE    = 3,
    parameter int LOCK_HITS = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_word,
    input  logic [W-1:0] pattern,
    input  logic         align_en,
    output logic [W-1:0] word_out,
    output logic         slip,
    output logic         aligned,
    output logic         wrap_err
);

    localparam int OFF_W = $clog2(W);

    logic [OFF_W-1:0] offset;

    rl_window #(.W(W), .OFF_W(OFF_W)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_word (raw_word),
        .offset   (offset),
        .word     (word_out)
    );

    rl_ctrl #(.W(W), .SETTLE(SETTLE), .LOCK_HITS(LOCK_HITS), .OFF_W(OFF_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .word     (word_out),
        .pattern  (pattern),
        .align_en (align_en),
        .offset   (offset),
        .slip     (slip),
        .aligned  (aligned),
        .wrap_err (wrap_err)
    );

endmodule

// File: rtl/word_realigner_chk.sv
module word_realigner_chk #(
    parameter int W = 10
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] word_out,
    input logic [W-1:0] pattern,
    input logic         align_en,
    input logic         slip,
    input logic         aligned,
    input logic         wrap_err
);

    // R3
    slip_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slip |-> !$past(slip) && !$past(slip, 2) && !$past(slip, 3));

    // R4
    slip_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slip |-> $past(align_en));

    // R5
    lock_two_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aligned) |-> $past(word_out == pattern) && $past(word_out == pattern, 2));

    // R5
    no_slip_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aligned |-> !slip);

    // R6
    err_with_slip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wrap_err) |-> slip);

    // R7
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !align_en |=> $stable(aligned) && $stable(wrap_err));

endmodule

bind word_realigner word_realigner_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_out (word_out),
    .pattern  (pattern),
    .align_en (align_en),
    .slip     (slip),
    .aligned  (aligned),
    .wrap_err (wrap_err)
);

// File: tb/word_realigner_tb.sv
module word_realigner_tb;

    localparam int W = 10;
    localparam logic [W-1:0] PAT = 10'b0011111010;
    localparam int NV = 5;
    localparam int PHASE [NV] = '{3, 3, 9, 0, 5};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] raw_word = '0;
    logic [W-1:0] pattern = PAT;
    logic         align_en = 1'b0;
    logic [W-1:0] word_out;
    logic         slip, aligned, wrap_err;

    int checks = 0;
    int bad = 0;
    int off_model = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    word_realigner u_dut (
        .clk(clk), .rst_n(rst_n), .raw_word(raw_word), .pattern(pattern),
        .align_en(align_en), .word_out(word_out), .slip(slip),
        .aligned(aligned), .wrap_err(wrap_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] stream_word(input int p);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) r[(i + p) % W] = PAT[i];
        return r;
    endfunction

    task automatic restart(input logic [W-1:0] data);
        @(negedge clk);
        align_en = 1'b0;
        raw_word = data;
        repeat (4) @(negedge clk);
        align_en = 1'b1;
    endtask

    task automatic wait_lock(output int n_slips, output logic locked);
        n_slips = 0;
        locked = 1'b0;
        for (int c = 0; c < 400; c++) begin
            @(negedge clk);
            if (slip) n_slips++;
            if (aligned) begin
                locked = 1'b1;
                break;
            end
        end
    endtask

    initial begin
        int   ns;
        logic lk;
        repeat (3) @(negedge clk);
        // R8 reset state
        chk("R8 word_out", word_out, 0);
        chk("R8 slip", slip, 0);
        chk("R8 aligned", aligned, 0);
        chk("R8 wrap_err", wrap_err, 0);
        rst_n = 1'b1;

        // vector table walk: R1, R2, R5
        for (int v = 0; v < NV; v++) begin
            restart(stream_word(PHASE[v]));
            wait_lock(ns, lk);
            chk("R5 locked", lk, 1);
            chk("R1 word at lock", word_out, PAT);
            chk("R2 slip count", ns, (PHASE[v] - off_model + W) % W);
            chk("R6 no error", wrap_err, 0);
            off_model = PHASE[v];
        end

        // R5: data changes after lock, no slip
        raw_word = '0;
        ns = 0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (slip) ns++;
        end
        chk("R5 no slip when locked", ns, 0);
        chk("R5 aligned held", aligned, 1);

        // R4: enable low, mismatching data, no slip
        align_en = 1'b0;
        ns = 0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (slip) ns++;
        end
        chk("R4 no slip while disabled", ns, 0);
        chk("R7 aligned kept while disabled", aligned, 1);

        // R6: no match anywhere
        restart('0);
        @(negedge clk);
        chk("R7 aligned cleared", aligned, 0);
        ns = 0;
        for (int c = 0; c < 200 && ns < 12; c++) begin
            if (slip) begin
                ns++;
                if (ns == 9)  chk("R6 no error at 9th slip", wrap_err, 0);
                if (ns == 10) chk("R6 error at 10th slip", wrap_err, 1);
            end
            @(negedge clk);
        end
        chk("R6 search continues", ns, 12);
        raw_word = stream_word(7);
        wait_lock(ns, lk);
        chk("R6 locks after wrap", lk, 1);
        chk("R1 word after wrap", word_out, PAT);
        chk("R6 error sticky", wrap_err, 1);

        // R7: re-enable clears flags
        restart('0);
        @(negedge clk);
        chk("R7 aligned cleared", aligned, 0);
        chk("R7 wrap_err cleared", wrap_err, 0);

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule